// File: doc/BRIEF.md
# Sticky Interrupt Status and Mask Unit

This unit collects event notifications for a configuration controller into a 32-bit sticky status word and combines them, through a 32-bit disable mask, into one interrupt line. Single-cycle event pulses from transfer and bus logic elsewhere arrive on a 32-bit input vector. The state of the fabric initialisation line and the fabric done line is turned into status events by the unit itself. Software reads both words over a simple register bus. It acknowledges events by writing ones to the status word, and it picks which events may interrupt by writing the mask, in which a one disables a source.

Only a fixed set of positions exists (0xF8F7F87F). Every other position ignores events and writes and reads as zero. A separate error summary output shows whether any status bit inside the error group 0x00F0F860 is pending, whatever the mask holds.

The initialisation line is followed by a three-state machine. LN_UNKNOWN is the state after reset. On the first sampled cycle it moves to LN_LOW or LN_HIGH according to the line, and it reports no edge on that move. LN_LOW goes to LN_HIGH when the line is sampled high, which reports a rising edge. LN_HIGH goes to LN_LOW when the line is sampled low, which reports a falling edge. In every other case the state holds.

Top module: `cfg_irq_unit`

## Requirements
- R1: After reset the status word reads 0, the mask reads 0xF8F7F87F (every implemented source disabled), and irq_o and err_any_o are 0.
- R2: A one on evt_i at an implemented position other than 0 to 2 sets that status bit at the next clock edge. The bit stays set after the pulse ends.
- R3: A write to the status word (reg_addr 0) clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R4: Status positions outside 0xF8F7F87F, and evt_i positions 0 to 2, ignore events. Mask positions outside 0xF8F7F87F ignore writes. Both words read zero at unimplemented positions. Reads of addresses 2 and 3 return 0, and writes to them change nothing.
- R5: When an event sets a status bit in the same cycle as a software write clears it, the bit ends up set.
- R6: A low-to-high change of fab_init_i sets status bit 1, and a high-to-low change sets status bit 0. A level held steady sets neither bit. The first sample after reset sets neither bit, whatever the level.
- R7: Status bit 2 is set at every clock edge at which fab_done_i is high, so it cannot be cleared while done stays high.
- R8: irq_o is 1 exactly one clock edge after the cycle in which some status bit is 1 and its mask bit is 0.
- R9: A mask write (reg_addr 1) of all ones disables every source. Writing the bitwise inverse of one source's bit enables only that source.
- R10: err_any_o is 1, in the same cycle as the status, whenever a status bit inside 0x00F0F860 is set, whatever the mask holds. Pending status outside that group leaves it 0.
- R11: reg_rdata is loaded at the clock edge of a cycle with reg_rd_en high, with the value the addressed word held before that edge. It holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Word index: 0 status, 1 mask |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| evt_i | input | DATA_W | Event set pulses, one per status position |
| fab_init_i | input | 1 | Fabric initialisation line, synchronous |
| fab_done_i | input | 1 | Fabric done line, synchronous |
| irq_o | output | 1 | Registered interrupt request |
| err_any_o | output | 1 | Any error-group status bit pending |

## Verification
A wrong line-tracker state shows up on the first sampled cycle after the error. A spurious or missing edge appears in status bit 0 or 1 on the next status read. A status bit that is lost or wrongly kept becomes visible at the next read, at err_any_o in the same cycle if the bit is in the error group, and at irq_o one edge later if the bit is enabled. A corrupted mask bit changes irq_o one edge after the status and mask disagree. It also reads back directly from address 1.

// File: rtl/cfg_irq_unit_pkg.sv
package cfg_irq_unit_pkg;

    localparam int          DATA_W_DEF    = 32;
    localparam logic [31:0] IMPL_BITS_DEF = 32'hF8F7_F87F;
    localparam logic [31:0] ERR_BITS_DEF  = 32'h00F0_F860;

    localparam int BIT_INIT_FALL = 0;
    localparam int BIT_INIT_RISE = 1;
    localparam int BIT_DONE      = 2;

    localparam int ADDR_STATUS = 0;
    localparam int ADDR_MASK   = 1;

    typedef enum logic [1:0] {
        LN_UNKNOWN = 2'd0,
        LN_LOW     = 2'd1,
        LN_HIGH    = 2'd2
    } line_state_e;

endpackage

// File: rtl/cfg_line_tracker.sv
module cfg_line_tracker
    import cfg_irq_unit_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic rise_o,
    output logic fall_o
);

    line_state_e state_q;
    line_state_e state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LN_UNKNOWN: state_d = line_i ? LN_HIGH : LN_LOW;
            LN_LOW:     if (line_i)  state_d = LN_HIGH;
            LN_HIGH:    if (!line_i) state_d = LN_LOW;
            default:    state_d = LN_UNKNOWN;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LN_UNKNOWN;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        rise_o = 1'b0;
        fall_o = 1'b0;
        unique case (state_q)
            LN_UNKNOWN: ;
            LN_LOW:     rise_o = line_i;
            LN_HIGH:    fall_o = !line_i;
            default:    ;
        endcase
    end

    // R6: never both edges at once
    p_edge_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rise_o, fall_o}));

    // R6: a rising report is followed by the high state, so no repeat
    p_no_repeat_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/cfg_sticky_bank.sv
module cfg_sticky_bank #(
    parameter int              W    = 32,
    parameter logic [W-1:0]    IMPL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] stat_o
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (IMPL[i]) begin : g_impl
            logic bit_q;
            always_ff @(posedge clk) begin
                if (!rst_n)        bit_q <= 1'b0;
                else if (set_i[i]) bit_q <= 1'b1;   // set wins over clear
                else if (clr_i[i]) bit_q <= 1'b0;
            end
            assign stat_o[i] = bit_q;
        end else begin : g_none
            assign stat_o[i] = 1'b0;
        end
    end

    // R2: a set bit stays set unless cleared
    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_o & $past(stat_o & ~clr_i)) == $past(stat_o & ~clr_i)));

    // R5: an implemented set always lands
    p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_o & $past(set_i & IMPL)) == $past(set_i & IMPL)));

    // R4: unimplemented positions stay zero
    p_unimpl_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_o & ~IMPL) == '0);

endmodule

// File: rtl/cfg_mask_reg.sv
module cfg_mask_reg #(
    parameter int           W    = 32,
    parameter logic [W-1:0] IMPL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] mask_o
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (IMPL[i]) begin : g_impl
            logic bit_q;
            always_ff @(posedge clk) begin
                if (!rst_n)    bit_q <= 1'b1;
                else if (wr_i) bit_q <= wdata_i[i];
            end
            assign mask_o[i] = bit_q;
        end else begin : g_none
            assign mask_o[i] = 1'b0;
        end
    end

    // R9: without a write the mask holds
    p_mask_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(mask_o));

endmodule

// File: rtl/cfg_irq_combine.sv
module cfg_irq_combine #(
    parameter int           W   = 32,
    parameter logic [W-1:0] ERR = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] stat_i,
    input  logic [W-1:0] mask_i,
    output logic         irq_o,
    output logic         err_any_o
);

    logic irq_q;

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(stat_i & ~mask_i);
    end

    assign irq_o     = irq_q;
    assign err_any_o = |(stat_i & ERR);

    // R9: fully masked means no interrupt one edge later
    p_masked_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_i == '1 || stat_i == '0) |=> !irq_o);

    // R10: summary implies some pending status
    p_err_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err_any_o |-> (stat_i != '0));

endmodule

// File: rtl/cfg_irq_unit.sv
module cfg_irq_unit
    import cfg_irq_unit_pkg::*;
#(
    parameter int                DATA_W    = DATA_W_DEF,
    parameter int                ADDR_W    = 2,
    parameter logic [DATA_W-1:0] IMPL_BITS = IMPL_BITS_DEF,
    parameter logic [DATA_W-1:0] ERR_BITS  = ERR_BITS_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [DATA_W-1:0] evt_i,
    input  logic              fab_init_i,
    input  logic              fab_done_i,
    output logic              irq_o,
    output logic              err_any_o
);

    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADDR_STATUS);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(ADDR_MASK);

    logic              init_rise;
    logic              init_fall;
    logic              wr_stat;
    logic              wr_mask;
    logic [DATA_W-1:0] set_vec;
    logic [DATA_W-1:0] clr_vec;
    logic [DATA_W-1:0] stat;
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] rdata_q;

    assign wr_stat = reg_wr_en && (reg_addr == A_STAT);
    assign wr_mask = reg_wr_en && (reg_addr == A_MASK);
    assign clr_vec = wr_stat ? reg_wdata : '0;

    always_comb begin
        set_vec                = evt_i;
        set_vec[BIT_INIT_FALL] = init_fall;
        set_vec[BIT_INIT_RISE] = init_rise;
        set_vec[BIT_DONE]      = fab_done_i;
    end

    cfg_line_tracker u_init (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (fab_init_i),
        .rise_o (init_rise),
        .fall_o (init_fall)
    );

    cfg_sticky_bank #(.W(DATA_W), .IMPL(IMPL_BITS)) u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_vec),
        .clr_i  (clr_vec),
        .stat_o (stat)
    );

    cfg_mask_reg #(.W(DATA_W), .IMPL(IMPL_BITS)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr_mask),
        .wdata_i (reg_wdata),
        .mask_o  (mask)
    );

    cfg_irq_combine #(.W(DATA_W), .ERR(ERR_BITS)) u_comb (
        .clk       (clk),
        .rst_n     (rst_n),
        .stat_i    (stat),
        .mask_i    (mask),
        .irq_o     (irq_o),
        .err_any_o (err_any_o)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (reg_rd_en) begin
            if (reg_addr == A_STAT)      rdata_q <= stat;
            else if (reg_addr == A_MASK) rdata_q <= mask;
            else                         rdata_q <= '0;
        end
    end

    assign reg_rdata = rdata_q;

    // R11: read data holds when no read is issued
    p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd_en |=> $stable(reg_rdata));

    // R7: done high always leaves bit 2 set
    p_done_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fab_done_i |=> stat[BIT_DONE]);

endmodule

// File: tb/cfg_irq_unit_tb_top.sv
module cfg_irq_unit_tb_top;

    localparam logic [31:0] IMPL = 32'hF8F7_F87F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic        reg_rd_en = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] evt_i = '0;
    logic        fab_init_i = 1'b0;
    logic        fab_done_i = 1'b0;
    logic        irq_o;
    logic        err_any_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    cfg_irq_unit dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr_en  (reg_wr_en),
        .reg_rd_en  (reg_rd_en),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .evt_i      (evt_i),
        .fab_init_i (fab_init_i),
        .fab_done_i (fab_done_i),
        .irq_o      (irq_o),
        .err_any_o  (err_any_o)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [1:0] a, input logic [31:0] d);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr_en = 1'b0; reg_wdata = '0;
    endtask

    task automatic read_reg(input logic [1:0] a, output logic [31:0] d);
        reg_rd_en = 1'b1; reg_addr = a;
        tick();
        reg_rd_en = 1'b0;
        d = reg_rdata;
    endtask

    task automatic pulse(input logic [31:0] v);
        evt_i = v;
        tick();
        evt_i = '0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 irq", {31'b0, irq_o}, 32'd0);
        check("R1 err", {31'b0, err_any_o}, 32'd0);
        read_reg(2'd0, d); check("R1 status", d, 32'd0);
        read_reg(2'd1, d); check("R1 mask", d, IMPL);
    endtask

    task automatic t_sticky();
        logic [31:0] d;
        pulse(32'h0000_2000);
        tick(); tick();
        read_reg(2'd0, d); check("R2 sticky", d, 32'h0000_2000);
        write_reg(2'd0, 32'hFFFF_FFFF);
    endtask

    task automatic t_w1c();
        logic [31:0] d;
        pulse(32'h0000_D000);
        write_reg(2'd0, 32'h0);
        read_reg(2'd0, d); check("R3 write zero", d, 32'h0000_D000);
        write_reg(2'd0, 32'h0000_4000);
        read_reg(2'd0, d); check("R3 clear one", d, 32'h0000_9000);
        write_reg(2'd0, 32'hFFFF_FFFF);
        read_reg(2'd0, d); check("R3 clear all", d, 32'h0);
    endtask

    task automatic t_unimpl();
        logic [31:0] d;
        pulse(~IMPL | 32'h7);
        read_reg(2'd0, d); check("R4 status unimpl", d, 32'h0);
        write_reg(2'd1, 32'hFFFF_FFFF);
        read_reg(2'd1, d); check("R4 mask unimpl", d, IMPL);
        write_reg(2'd3, 32'h0);
        read_reg(2'd1, d); check("R4 addr3 write", d, IMPL);
        read_reg(2'd2, d); check("R4 addr2 read", d, 32'h0);
    endtask

    task automatic t_setwins();
        logic [31:0] d;
        pulse(32'h0010_0000);
        evt_i = 32'h0010_0000;
        write_reg(2'd0, 32'h0010_0000);
        evt_i = '0;
        read_reg(2'd0, d); check("R5 set wins", d, 32'h0010_0000);
        write_reg(2'd0, 32'h0010_0000);
        read_reg(2'd0, d); check("R5 later clear", d, 32'h0);
    endtask

    task automatic t_init();
        logic [31:0] d;
        fab_init_i = 1'b1;
        tick();
        read_reg(2'd0, d); check("R6 rise", d, 32'h2);
        write_reg(2'd0, 32'h3);
        tick(); tick();
        read_reg(2'd0, d); check("R6 steady high", d, 32'h0);
        fab_init_i = 1'b0;
        tick();
        read_reg(2'd0, d); check("R6 fall", d, 32'h1);
        write_reg(2'd0, 32'h3);
        fab_init_i = 1'b1;
        do_reset();
        tick(); tick();
        read_reg(2'd0, d); check("R6 first sample", d, 32'h0);
        fab_init_i = 1'b0;
        tick();
        write_reg(2'd0, 32'hFFFF_FFFF);
    endtask

    task automatic t_done();
        logic [31:0] d;
        fab_done_i = 1'b1;
        tick();
        read_reg(2'd0, d); check("R7 done set", d, 32'h4);
        write_reg(2'd0, 32'h4);
        read_reg(2'd0, d); check("R7 clear while high", d, 32'h4);
        fab_done_i = 1'b0;
        write_reg(2'd0, 32'h4);
        read_reg(2'd0, d); check("R7 clear after low", d, 32'h0);
    endtask

    task automatic t_irq();
        pulse(32'h0000_2000);
        tick();
        check("R9 all masked", {31'b0, irq_o}, 32'd0);
        write_reg(2'd1, ~32'h0000_1000);
        tick();
        check("R9 other source enabled", {31'b0, irq_o}, 32'd0);
        write_reg(2'd1, ~32'h0000_2000);
        check("R8 latency", {31'b0, irq_o}, 32'd0);
        tick();
        check("R8 irq asserted", {31'b0, irq_o}, 32'd1);
        write_reg(2'd1, 32'hFFFF_FFFF);
        check("R8 still one edge", {31'b0, irq_o}, 32'd1);
        tick();
        check("R9 disabled all", {31'b0, irq_o}, 32'd0);
        write_reg(2'd0, 32'hFFFF_FFFF);
    endtask

    task automatic t_err();
        pulse(32'h0040_0000);
        check("R10 error pending", {31'b0, err_any_o}, 32'd1);
        check("R10 irq masked", {31'b0, irq_o}, 32'd0);
        write_reg(2'd0, 32'h0040_0000);
        check("R10 cleared", {31'b0, err_any_o}, 32'd0);
        pulse(32'h8002_0000);
        check("R10 non-error", {31'b0, err_any_o}, 32'd0);
        write_reg(2'd0, 32'hFFFF_FFFF);
    endtask

    task automatic t_rdata();
        logic [31:0] d;
        evt_i = 32'h8000_0000;
        read_reg(2'd0, d);
        evt_i = '0;
        check("R11 pre-edge value", d, 32'h0);
        tick();
        check("R11 holds", reg_rdata, 32'h0);
        read_reg(2'd0, d); check("R11 new value", d, 32'h8000_0000);
        write_reg(2'd0, 32'hFFFF_FFFF);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        tick();
        t_reset();
        t_sticky();
        t_w1c();
        t_unimpl();
        t_setwins();
        t_init();
        t_done();
        t_irq();
        t_err();
        t_rdata();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule